// File: doc/BRIEF.md
# Two-Level TLB Maintenance Engine

This block holds the per-entry bookkeeping of a translation buffer that is split in two. The lower part is set-associative, with `WAYS` ways of `SETS` sets, and all its entries share one page size supplied on `shared_ps`. The upper part is fully associative with `FA_N` entries, and each of those entries keeps its own page size. For every entry the engine stores a virtual page-pair number, an address-space identifier, a global flag and an exists flag. The block does not translate addresses and does not walk page tables.

Single-cycle commands write one entry. A directed write goes to a given index, and it can instead drop the entry when the not-exist flag is set. A fill picks its own index by random replacement, using a free-running 16-bit LFSR reduced modulo the range. Maintenance commands clear exists flags. They step through their target entries one per cycle, hold `busy` high while they work, and end with a one-cycle `done` pulse. A read port exposes any entry so that the surrounding pipeline can inspect it.

Top module: `tlb_maint_engine`

## Requirements
- R1: Index i < WAYS*SETS names way i/SETS, set i mod SETS of the set-associative part. Indices from WAYS*SETS up to WAYS*SETS+FA_N-1 name the fully associative entries. For a set-associative index, `rd_ps` returns `shared_ps`.
- R2: A fill (`cmd_op`=1) whose `cmd_ps` equals `shared_ps` writes index way*SETS+set. The way is a random value in 0..WAYS-1 and the set is (`cmd_vaddr` >> (`cmd_ps`+1)) mod SETS. `wr_ack` and `wr_idx` report the index one cycle after acceptance.
- R3: A fill with any other page size writes a random fully associative index and stores `cmd_ps` in that entry.
- R4: A write (`cmd_op`=2) with `cmd_ne`=1 clears only the exists flag of entry `cmd_index`. Every other entry keeps its state.
- R5: A write with `cmd_ne`=0, and every fill, loads `cmd_vaddr`[VA_W-1:13] as the page-pair number, `cur_asid` as the ASID and `cmd_g` as the global flag, and sets exists to 1. A page size is kept only in fully associative entries.
- R6: A clear (`cmd_op`=3) whose index is set-associative clears exists in all ways of set `cmd_index` mod SETS where the entry is non-global and its ASID equals `cur_asid`.
- R7: A clear whose index is fully associative applies the same test to every fully associative entry and leaves the set-associative part unchanged.
- R8: A flush (`cmd_op`=4) covers the same entries as a clear but clears them whatever their ASID and global flag.
- R9: Invalidate-all (`cmd_op`=5) clears every entry. Invalidate-by-global (`cmd_op`=6) clears the entries whose global flag equals `cmd_g`.
- R10: Invalidate-by-ASID (`cmd_op`=7) clears the non-global entries whose ASID equals `cmd_asid`.
- R11: A page-matched invalidate compares `cmd_vaddr` with the stored page-pair number over address bits [VA_W-1 : ps+1]. Here ps is `shared_ps` for a set-associative entry and the stored size for a fully associative entry. `cmd_op`=8 clears non-global entries with a matching ASID and page. `cmd_op`=9 clears entries with a matching page that are global or have a matching ASID.
- R12: `busy` is high from the cycle after a maintenance command is accepted until its last entry is processed. `done` is high for one cycle, with `busy` low, right after that. Commands presented while `busy` is high are ignored.
- R13: A write, clear or flush whose index is at or above WAYS*SETS+FA_N changes nothing and raises neither `wr_ack` nor `busy`.
- R14: After reset every exists flag is 0 and `busy`, `done` and `wr_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code (1 fill … 9 page/ASID-or-global invalidate) |
| cmd_index | input | IW | Target index for write, clear, flush |
| cmd_ne | input | 1 | Not-exist flag for write |
| cmd_vaddr | input | VA_W | Virtual address for write, fill, page invalidates |
| cmd_ps | input | PS_W | Page size of the entry being written or filled |
| cmd_g | input | 1 | Global flag to load, or operand of invalidate-by-global |
| cmd_asid | input | ASID_W | ASID operand of the invalidates |
| cur_asid | input | ASID_W | Current ASID, loaded on writes and used by clear |
| shared_ps | input | PS_W | Page size of the set-associative part |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| wr_ack | output | 1 | A write or fill took effect in the previous cycle |
| wr_idx | output | IW | Index written by that write or fill |
| rd_idx | input | IW | Read-port index |
| rd_exists | output | 1 | Exists flag of the read entry |
| rd_vppn | output | VA_W-13 | Page-pair number of the read entry |
| rd_asid | output | ASID_W | ASID of the read entry |
| rd_g | output | 1 | Global flag of the read entry |
| rd_ps | output | PS_W | Page size that applies to the read entry |

## Verification
Two functions can meet in one cycle: a new command can arrive while a sweep is still clearing entries. The bench provokes this by presenting a write to an empty index in the cycle after a flush starts. It judges the result at the ports: `wr_ack` must stay low, and the read port must still show the target entry as absent after `done`. The bench also checks that `done` lasts exactly one cycle. The random fill indices are not predicted. Instead the bench checks the set bits, the part of the buffer that was chosen, and the contents that can be read back at the reported index.

// File: rtl/tlb_maint_engine.sv
module tlb_maint_engine #(
  parameter int WAYS     = 8,
  parameter int SETS     = 256,
  parameter int FA_N     = 64,
  parameter int VA_W     = 48,
  parameter int ASID_W   = 10,
  parameter int PS_W     = 6,
  parameter int PAGE_LSB = 13,
  localparam int SA_N    = WAYS * SETS,
  localparam int TOT     = SA_N + FA_N,
  localparam int IW      = $clog2(TOT),
  localparam int VPW     = VA_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [IW-1:0]     cmd_index,
  input  logic              cmd_ne,
  input  logic [VA_W-1:0]   cmd_vaddr,
  input  logic [PS_W-1:0]   cmd_ps,
  input  logic              cmd_g,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [PS_W-1:0]   shared_ps,
  output logic              busy,
  output logic              done,
  output logic              wr_ack,
  output logic [IW-1:0]     wr_idx,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_exists,
  output logic [VPW-1:0]    rd_vppn,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_g,
  output logic [PS_W-1:0]   rd_ps
);

  localparam int FW = (FA_N > 1) ? $clog2(FA_N) : 1;
  localparam logic [3:0] OP_FILL = 4'd1, OP_WRITE = 4'd2, OP_CLEAR = 4'd3,
                         OP_FLUSH = 4'd4, OP_INV_ALL = 4'd5, OP_INV_G = 4'd6,
                         OP_INV_ASID = 4'd7, OP_INV_PA = 4'd8, OP_INV_PAG = 4'd9;
  localparam logic [1:0] SC_SET = 2'd0, SC_FA = 2'd1, SC_ALL = 2'd2;

  logic [TOT-1:0]    e_q;
  logic [TOT-1:0]    g_q;
  logic [VPW-1:0]    vppn_q [TOT];
  logic [ASID_W-1:0] asid_q [TOT];
  logic [PS_W-1:0]   ps_q   [FA_N];

  logic [15:0]       lfsr_q;
  logic              busy_q, done_q, wr_ack_q;
  logic [IW-1:0]     wr_idx_q;
  logic [3:0]        op_q;
  logic [1:0]        scope_q;
  logic [IW-1:0]     cnt_q, base_q, last_q;
  logic [ASID_W-1:0] par_asid_q;
  logic              par_g_q;
  logic [VA_W-1:0]   par_va_q;

  assign busy   = busy_q;
  assign done   = done_q;
  assign wr_ack = wr_ack_q;
  assign wr_idx = wr_idx_q;

  wire accept  = cmd_valid && !busy_q;
  wire in_rng  = 32'(cmd_index) < TOT;
  wire in_sa   = 32'(cmd_index) < SA_N;
  wire is_cf   = (cmd_op == OP_CLEAR) || (cmd_op == OP_FLUSH);
  wire is_inv  = (cmd_op >= OP_INV_ALL) && (cmd_op <= OP_INV_PAG);
  wire do_wr   = accept && ((cmd_op == OP_WRITE && in_rng) || cmd_op == OP_FILL);
  wire wr_load = !(cmd_op == OP_WRITE && cmd_ne);
  wire start   = accept && ((is_cf && in_rng) || is_inv);

  logic [VA_W-1:0] fill_shift;
  logic [IW-1:0]   fill_tgt, wr_tgt;
  always_comb begin
    fill_shift = cmd_vaddr >> (32'(cmd_ps) + 1);
    if (cmd_ps == shared_ps)
      fill_tgt = IW'(32'(lfsr_q % 16'(WAYS)) * SETS + 32'(fill_shift % VA_W'(SETS)));
    else
      fill_tgt = IW'(SA_N + 32'(lfsr_q % 16'(FA_N)));
    wr_tgt = (cmd_op == OP_FILL) ? fill_tgt : cmd_index;
  end

  logic [IW-1:0]   idx_s, fa_off_w;
  logic [PS_W-1:0] ent_ps;
  logic [VA_W-1:0] page_mask;
  logic            ent_g, asid_eq, pg_hit, hit;
  always_comb begin
    idx_s = (scope_q == SC_SET) ? IW'(32'(base_q) + 32'(cnt_q) * SETS)
                                : IW'(32'(base_q) + 32'(cnt_q));
    fa_off_w  = idx_s - IW'(SA_N);
    ent_ps    = (32'(idx_s) >= SA_N) ? ps_q[fa_off_w[FW-1:0]] : shared_ps;
    page_mask = ~((VA_W'(1) << (32'(ent_ps) + 1)) - VA_W'(1));
    pg_hit    = ((par_va_q ^ {vppn_q[idx_s], PAGE_LSB'(0)}) & page_mask) == '0;
    ent_g     = g_q[idx_s];
    asid_eq   = asid_q[idx_s] == par_asid_q;
    case (op_q)
      OP_CLEAR, OP_INV_ASID: hit = !ent_g && asid_eq;
      OP_FLUSH, OP_INV_ALL:  hit = 1'b1;
      OP_INV_G:              hit = ent_g == par_g_q;
      OP_INV_PA:             hit = !ent_g && asid_eq && pg_hit;
      OP_INV_PAG:            hit = (ent_g || asid_eq) && pg_hit;
      default:               hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= '0; lfsr_q <= 16'h0001;
      busy_q <= 1'b0; done_q <= 1'b0; wr_ack_q <= 1'b0; wr_idx_q <= '0;
      op_q <= '0; scope_q <= SC_ALL; cnt_q <= '0; base_q <= '0; last_q <= '0;
      par_asid_q <= '0; par_g_q <= 1'b0; par_va_q <= '0;
    end else begin
      lfsr_q   <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      done_q   <= 1'b0;
      wr_ack_q <= do_wr;
      if (do_wr) begin
        wr_idx_q     <= wr_tgt;
        e_q[wr_tgt]  <= wr_load;
      end
      if (start) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        op_q       <= cmd_op;
        par_asid_q <= (cmd_op == OP_CLEAR) ? cur_asid : cmd_asid;
        par_g_q    <= cmd_g;
        par_va_q   <= cmd_vaddr;
        if (is_cf && in_sa) begin
          scope_q <= SC_SET; base_q <= IW'(32'(cmd_index) % SETS); last_q <= IW'(WAYS - 1);
        end else if (is_cf) begin
          scope_q <= SC_FA;  base_q <= IW'(SA_N);                   last_q <= IW'(FA_N - 1);
        end else begin
          scope_q <= SC_ALL; base_q <= '0;                          last_q <= IW'(TOT - 1);
        end
      end
      if (busy_q) begin
        if (hit) e_q[idx_s] <= 1'b0;
        if (cnt_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  logic [IW-1:0] wr_off;
  assign wr_off = wr_tgt - IW'(SA_N);
  always_ff @(posedge clk) begin
    if (do_wr && wr_load) begin
      vppn_q[wr_tgt] <= cmd_vaddr[VA_W-1:PAGE_LSB];
      asid_q[wr_tgt] <= cur_asid;
      g_q[wr_tgt]    <= cmd_g;
      if (32'(wr_tgt) >= SA_N) ps_q[wr_off[FW-1:0]] <= cmd_ps;
    end
  end

  logic          rd_ok;
  logic [IW-1:0] rd_sel, rd_off;
  assign rd_ok     = 32'(rd_idx) < TOT;
  assign rd_sel    = rd_ok ? rd_idx : '0;
  assign rd_off    = rd_sel - IW'(SA_N);
  assign rd_exists = rd_ok && e_q[rd_sel];
  assign rd_vppn   = vppn_q[rd_sel];
  assign rd_asid   = asid_q[rd_sel];
  assign rd_g      = g_q[rd_sel];
  assign rd_ps     = (32'(rd_sel) >= SA_N) ? ps_q[rd_off[FW-1:0]] : shared_ps;

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && $past(cmd_op) == OP_WRITE |-> wr_idx == $past(cmd_index)); // R4
  AST_FILL_SHARED_PART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && $past(cmd_op) == OP_FILL && $past(cmd_ps) == $past(shared_ps)
    |-> 32'(wr_idx) < SA_N); // R2
  AST_FILL_OWN_PART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && $past(cmd_op) == OP_FILL && $past(cmd_ps) != $past(shared_ps)
    |-> 32'(wr_idx) >= SA_N && 32'(wr_idx) < TOT); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> !wr_ack); // R12
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ack, busy})); // R13

endmodule

// File: tb/sim_tlb_maint_engine.sv
module sim_tlb_maint_engine;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_ne = 0, cmd_g = 0;
  logic [3:0]  cmd_op = 0;
  logic [11:0] cmd_index = 0, rd_idx = 0;
  logic [47:0] cmd_vaddr = 0;
  logic [5:0]  cmd_ps = 0, shared_ps = 6'd12;
  logic [9:0]  cmd_asid = 0, cur_asid = 0;
  logic        busy, done, wr_ack, rd_exists, rd_g;
  logic [11:0] wr_idx;
  logic [34:0] rd_vppn;
  logic [9:0]  rd_asid;
  logic [5:0]  rd_ps;

  tlb_maint_engine u0 (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_index, .cmd_ne,
    .cmd_vaddr, .cmd_ps, .cmd_g, .cmd_asid, .cur_asid, .shared_ps, .busy, .done,
    .wr_ack, .wr_idx, .rd_idx, .rd_exists, .rd_vppn, .rd_asid, .rd_g, .rd_ps);

  int nchk = 0, nfail = 0;

  localparam int NROW = 6;
  localparam logic [11:0] T_IDX  [NROW] = '{12'd5, 12'd261, 12'd517, 12'd2048, 12'd2049, 12'd2050};
  localparam logic [47:0] T_VA   [NROW] = '{48'h0000_1234_A000, 48'h0000_1234_A000, 48'h0000_5678_0000,
                                            48'h0000_4000_0000, 48'h0000_7000_8000, 48'h0000_0ABC_D000};
  localparam logic [9:0]  T_ASID [NROW] = '{10'd1, 10'd2, 10'd1, 10'd1, 10'd3, 10'd1};
  localparam logic        T_G    [NROW] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [5:0]  T_PS   [NROW] = '{6'd0, 6'd0, 6'd0, 6'd21, 6'd14, 6'd12};

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, a, e);
    end
  endtask

  task automatic peek(input logic [11:0] idx);
    rd_idx = idx;
    #1;
  endtask

  task automatic ex(input string r, input logic [11:0] idx, input logic e);
    peek(idx);
    chk(r, 64'(rd_exists), 64'(e));
  endtask

  task automatic issue(input logic [3:0] op, input logic [11:0] idx, input logic ne,
                       input logic [47:0] va, input logic [5:0] ps, input logic g,
                       input logic [9:0] asid);
    @(negedge clk);
    cmd_op = op; cmd_index = idx; cmd_ne = ne; cmd_vaddr = va; cmd_ps = ps;
    cmd_g = g; cmd_asid = asid; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic populate(input bit verify);
    for (int i = 0; i < NROW; i++) begin
      cur_asid = T_ASID[i];
      issue(4'd2, T_IDX[i], 1'b0, T_VA[i], T_PS[i], T_G[i], 10'd0);
      if (verify) begin
        chk("R1 wr_ack", 64'(wr_ack), 64'd1);
        chk("R1 wr_idx", 64'(wr_idx), 64'(T_IDX[i]));
        peek(T_IDX[i]);
        chk("R5 exists", 64'(rd_exists), 64'd1);
        chk("R5 vppn", 64'(rd_vppn), 64'(T_VA[i][47:13]));
        chk("R5 asid", 64'(rd_asid), 64'(T_ASID[i]));
        chk("R5 g", 64'(rd_g), 64'(T_G[i]));
        chk("R1 R5 ps", 64'(rd_ps), (T_IDX[i] < 12'd2048) ? 64'd12 : 64'(T_PS[i]));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    chk("R14 busy", 64'(busy), 0);
    chk("R14 done", 64'(done), 0);
    chk("R14 wr_ack", 64'(wr_ack), 0);
    ex("R14 exists", 12'd5, 0);
    rst_n = 1;
    @(negedge clk);
    ex("R14 exists fa", 12'd2050, 0);

    populate(1);

    // R4 write with not-exist flag
    issue(4'd2, 12'd517, 1'b1, 48'h0, 6'd0, 1'b0, 10'd0);
    ex("R4 target", 12'd517, 0);
    ex("R4 other", 12'd5, 1);
    ex("R4 other2", 12'd261, 1);

    // R13 out-of-range indices
    issue(4'd2, 12'd2200, 1'b0, 48'h0, 6'd0, 1'b0, 10'd0);
    chk("R13 write ack", 64'(wr_ack), 0);
    issue(4'd3, 12'd3000, 1'b0, 48'h0, 6'd0, 1'b0, 10'd0);
    chk("R13 clear busy", 64'(busy), 0);
    ex("R13 untouched", 12'd5, 1);

    // R6 clear of one set
    populate(0);
    cur_asid = 10'd1;
    issue(4'd3, 12'd773, 1'b0, 48'h0, 6'd0, 1'b0, 10'd0);
    wait_done();
    ex("R6 cleared", 12'd5, 0);
    ex("R6 other asid", 12'd261, 1);
    ex("R6 global", 12'd517, 1);
    ex("R6 fa untouched", 12'd2048, 1);

    // R7 clear of fully associative part
    issue(4'd3, 12'd2100, 1'b0, 48'h0, 6'd0, 1'b0, 10'd0);
    wait_done();
    ex("R7 cleared", 12'd2048, 0);
    ex("R7 cleared2", 12'd2050, 0);
    ex("R7 global", 12'd2049, 1);
    ex("R7 sa untouched", 12'd261, 1);

    // R8 flush, with R12 collision
    populate(0);
    issue(4'd4, 12'd261, 1'b0, 48'h0, 6'd0, 1'b0, 10'd0);
    chk("R12 busy", 64'(busy), 1);
    issue(4'd2, 12'd100, 1'b0, 48'h0000_0000_2000, 6'd0, 1'b0, 10'd0);
    chk("R12 ignored ack", 64'(wr_ack), 0);
    wait_done();
    chk("R12 done busy low", 64'(busy), 0);
    @(negedge clk);
    chk("R12 done pulse", 64'(done), 0);
    ex("R12 ignored write", 12'd100, 0);
    ex("R8 way0", 12'd5, 0);
    ex("R8 way1", 12'd261, 0);
    ex("R8 way2 global", 12'd517, 0);
    ex("R8 fa untouched", 12'd2048, 1);

    // R9
    populate(0);
    issue(4'd5, 12'd0, 1'b0, 48'h0, 6'd0, 1'b0, 10'd0);
    wait_done();
    ex("R9 all sa", 12'd5, 0);
    ex("R9 all fa", 12'd2049, 0);
    populate(0);
    issue(4'd6, 12'd0, 1'b0, 48'h0, 6'd0, 1'b1, 10'd0);
    wait_done();
    ex("R9 g sa", 12'd517, 0);
    ex("R9 g fa", 12'd2049, 0);
    ex("R9 nong sa", 12'd5, 1);
    ex("R9 nong fa", 12'd2048, 1);

    // R10
    populate(0);
    issue(4'd7, 12'd0, 1'b0, 48'h0, 6'd0, 1'b0, 10'd1);
    wait_done();
    ex("R10 hit sa", 12'd5, 0);
    ex("R10 hit fa", 12'd2048, 0);
    ex("R10 hit fa2", 12'd2050, 0);
    ex("R10 global", 12'd517, 1);
    ex("R10 other asid", 12'd261, 1);
    ex("R10 other asid fa", 12'd2049, 1);

    // R11 page-matched invalidates
    populate(0);
    issue(4'd8, 12'd0, 1'b0, T_VA[0], 6'd0, 1'b0, 10'd1);
    wait_done();
    ex("R11 pa hit", 12'd5, 0);
    ex("R11 pa asid miss", 12'd261, 1);
    ex("R11 pa page miss", 12'd2050, 1);
    issue(4'd8, 12'd0, 1'b0, T_VA[2], 6'd0, 1'b0, 10'd1);
    wait_done();
    ex("R11 pa global kept", 12'd517, 1);
    issue(4'd8, 12'd0, 1'b0, 48'h0000_4040_0000, 6'd0, 1'b0, 10'd1);
    wait_done();
    ex("R11 pa large page miss", 12'd2048, 1);
    issue(4'd9, 12'd0, 1'b0, 48'h0000_4012_3456, 6'd0, 1'b0, 10'd1);
    wait_done();
    ex("R11 pag large page hit", 12'd2048, 0);
    issue(4'd9, 12'd0, 1'b0, 48'h0000_7000_9FFF, 6'd0, 1'b0, 10'd7);
    wait_done();
    ex("R11 pag global hit", 12'd2049, 0);
    issue(4'd9, 12'd0, 1'b0, T_VA[5], 6'd0, 1'b0, 10'd7);
    wait_done();
    ex("R11 pag asid miss", 12'd2050, 1);

    // R2 fills in the set-associative part
    cur_asid = 10'd4;
    for (int k = 0; k < 4; k++) begin
      logic [47:0] va;
      logic [11:0] got;
      va = 48'(k * 69 + 3) << 13;
      issue(4'd1, 12'd0, 1'b0, va, 6'd12, 1'b0, 10'd0);
      got = wr_idx;
      chk("R2 ack", 64'(wr_ack), 1);
      chk("R2 part", 64'(got < 12'd2048), 1);
      chk("R2 set", 64'(got[7:0]), 64'((k * 69 + 3) & 255));
      peek(got);
      chk("R2 exists", 64'(rd_exists), 1);
      chk("R5 fill vppn", 64'(rd_vppn), 64'(va[47:13]));
      chk("R5 fill asid", 64'(rd_asid), 64'd4);
    end

    // R3 fills in the fully associative part
    for (int k = 0; k < 3; k++) begin
      logic [11:0] got;
      issue(4'd1, 12'd0, 1'b0, 48'h0000_0012_0000 + 48'(k) * 48'h20000, 6'd16, 1'b1, 10'd0);
      got = wr_idx;
      chk("R3 ack", 64'(wr_ack), 1);
      chk("R3 part", 64'(got >= 12'd2048 && got < 12'd2112), 1);
      peek(got);
      chk("R3 exists", 64'(rd_exists), 1);
      chk("R3 ps", 64'(rd_ps), 64'd16);
      chk("R5 fill g", 64'(rd_g), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule